// File: doc/BRIEF.md
# SMM entry and resume sequencer

This controller tracks a core's passage into and out of system-management mode. When a management interrupt arrives during normal execution, it enters the management state. At that moment it records whether the core was halted, clears the I/O restart byte and captures any interrupted I/O access as a packed 32-bit status word. While in the management state, the handler may overwrite the halt-restart byte and the I/O restart byte.

On a resume request, the sequencer checks the saved control-register, debug-register and segment images for illegal combinations. A bad image sends the core into a latched shutdown state. A good image produces exactly one of three outcomes: return to halt, re-execute the trapped I/O access, or continue. It also restores the derived long-mode-active and virtual-8086 bits and one canonicalised segment base. Instruction execution and storage of the save area belong to the surrounding core.

Top module: `smm_seq`

## Requirements
- R1: On a management interrupt taken from normal execution, the halt-restart byte becomes {7'b0, halted_i}.
- R2: On entry, the I/O restart byte is cleared to 00h. While in the management state, a handler write replaces the selected byte with hdl_data_i: hdl_sel_i=0 selects the halt-restart byte and hdl_sel_i=1 selects the I/O restart byte.
- R3: The status word captured at entry is [31:16] port, [15:7] zero, [6] 32-bit, [5] 16-bit, [4] 8-bit, [3] repeat, [2] string, [1] valid=1, [0] 1=IN/0=OUT. The size code io_size_i maps 0 to 8-bit, 1 to 16-bit, 2 to 32-bit, and 3 to no size bit. When io_act_i is 0 at entry, the whole word is 0.
- R4: A management interrupt is ignored while in the management state or in shutdown. Neither byte and not the status word changes.
- R5: A resume request outside the management state pulses ud_o for one cycle and produces no outcome and no state change.
- R6: A resume whose image is illegal pulses rsm_shut_o and holds shutdown_o high. The illegal cases are: PE=0 with PG=1; CD=0 with NW=1; any of cr0_i, dr6_i or dr7_i bits 63:32 set; LME=1, PG=1 and PAE=0; LME=1, PG=1, PAE=1, CS.L=1 and CS.D=1. The CR0 bits are PE=bit 0, NW=bit 29, CD=bit 30, PG=bit 31. Resume and management interrupts are ignored in shutdown.
- R7: Only init_i, nmi_i or reset leaves shutdown, and each returns the sequencer to normal execution.
- R8: A legal resume pulses exactly one of rsm_iorst_o, rsm_halt_o or rsm_cont_o in the cycle after the request. The I/O restart byte is tested first, then the halt-restart byte, and any non-zero byte counts as set. conflict_o pulses with rsm_iorst_o when the halt-restart byte is also non-zero.
- R9: halt_cyc_o pulses for one cycle, one cycle after rsm_halt_o.
- R10: On a legal resume, lma_o = LME & PG & PAE and vm_o = rflags_vm_i & PE & ~lma.
- R11: On a legal resume, base_o is seg_base_i sign-extended from bit VA_W-1 when seg_canon_i=1. When seg_canon_i=0, bits above VA_W-1 are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smi_i | input | 1 | Management interrupt |
| rsm_i | input | 1 | Resume request |
| init_i | input | 1 | Processor init |
| nmi_i | input | 1 | Non-maskable interrupt |
| halted_i | input | 1 | Core halted at interrupt |
| io_act_i | input | 1 | Interrupt arrived during an I/O access |
| io_port_i | input | 16 | Trapped port |
| io_size_i | input | 2 | Access size code |
| io_rep_i | input | 1 | Repeated access |
| io_str_i | input | 1 | String access |
| io_in_i | input | 1 | Access is an input |
| hdl_wr_i | input | 1 | Handler byte write |
| hdl_sel_i | input | 1 | 0 halt-restart, 1 I/O restart |
| hdl_data_i | input | 8 | Write data |
| cr0_i | input | 64 | Saved CR0 image |
| cr4_pae_i | input | 1 | Saved PAE |
| efer_lme_i | input | 1 | Saved LME |
| cs_l_i | input | 1 | Saved CS.L |
| cs_d_i | input | 1 | Saved CS.D |
| dr6_i | input | 64 | Saved DR6 image |
| dr7_i | input | 64 | Saved DR7 image |
| rflags_vm_i | input | 1 | Saved VM flag |
| seg_base_i | input | 64 | Saved segment base |
| seg_canon_i | input | 1 | 1 sign-extend, 0 clear upper bits |
| in_smm_o | output | 1 | In management state |
| shutdown_o | output | 1 | In shutdown |
| auto_halt_o | output | 8 | Halt-restart byte |
| io_restart_o | output | 8 | I/O restart byte |
| io_status_o | output | 32 | Trapped I/O status word |
| rsm_shut_o | output | 1 | Outcome: shutdown |
| rsm_halt_o | output | 1 | Outcome: return to halt |
| rsm_iorst_o | output | 1 | Outcome: restart I/O |
| rsm_cont_o | output | 1 | Outcome: continue |
| conflict_o | output | 1 | Both restart bytes were non-zero |
| ud_o | output | 1 | Resume outside management state |
| halt_cyc_o | output | 1 | Halt bus-cycle indication |
| lma_o | output | 1 | Restored long-mode-active |
| vm_o | output | 1 | Restored virtual-8086 flag |
| base_o | output | 64 | Restored segment base |

## Verification
The entry results (both bytes, the status word and in_smm_o) are registered on the edge that takes the interrupt. The resume results (outcome pulses, conflict_o, ud_o, lma_o, vm_o, base_o and shutdown_o) appear on the edge that takes the request, and halt_cyc_o follows one edge later. The bench drives every stimulus on a falling edge and samples on the next falling edge, so it reads each registered result half a cycle after the edge that produced it. It checks halt_cyc_o one further falling edge on. Single-cycle pulses are compared in the only cycle in which they may be high, and are checked low again in the next cycle.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SMM, ST_SHUT} smm_st_e;
  localparam int unsigned CR0_PE = 0;
  localparam int unsigned CR0_NW = 29;
  localparam int unsigned CR0_CD = 30;
  localparam int unsigned CR0_PG = 31;
endpackage

// File: rtl/smm_io_pack.sv
module smm_io_pack #(
  parameter int unsigned PORT_W = 16
) (
  input  logic              act_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [1:0]        size_i,
  input  logic              rep_i,
  input  logic              str_i,
  input  logic              in_i,
  output logic [31:0]       word_o
);
  localparam int unsigned RSV_W = 32 - PORT_W - 7;
  logic [2:0] sz;
  always_comb begin
    sz = 3'b000;
    case (size_i)
      2'd0: sz = 3'b001;
      2'd1: sz = 3'b010;
      2'd2: sz = 3'b100;
      default: sz = 3'b000;
    endcase
    word_o = act_i ? {port_i, {RSV_W{1'b0}}, sz, rep_i, str_i, 1'b1, in_i} : 32'h0;
  end
endmodule

// File: rtl/smm_img_check.sv
module smm_img_check
  import smm_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic [REG_W-1:0] cr0_i,
  input  logic             pae_i,
  input  logic             lme_i,
  input  logic             cs_l_i,
  input  logic             cs_d_i,
  input  logic [REG_W-1:0] dr6_i,
  input  logic [REG_W-1:0] dr7_i,
  output logic             bad_o
);
  localparam int unsigned HI = REG_W / 2;
  logic pe, pg, cd, nw, hi_set, lm_bad;
  always_comb begin
    pe = cr0_i[CR0_PE];
    pg = cr0_i[CR0_PG];
    cd = cr0_i[CR0_CD];
    nw = cr0_i[CR0_NW];
    hi_set = (|cr0_i[REG_W-1:HI]) | (|dr6_i[REG_W-1:HI]) | (|dr7_i[REG_W-1:HI]);
    lm_bad = lme_i & pg & (~pae_i | (cs_l_i & cs_d_i));
    bad_o = (~pe & pg) | (~cd & nw) | hi_set | lm_bad;
  end
endmodule

// File: rtl/smm_base_fix.sv
module smm_base_fix #(
  parameter int unsigned REG_W = 64,
  parameter int unsigned VA_W  = 48
) (
  input  logic [REG_W-1:0] base_i,
  input  logic             canon_i,
  output logic [REG_W-1:0] base_o
);
  logic top;
  assign top = canon_i & base_i[VA_W-1];
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b < VA_W) begin : g_keep
      assign base_o[b] = base_i[b];
    end else begin : g_ext
      assign base_o[b] = top;
    end
  end
endmodule

// File: rtl/smm_seq.sv
module smm_seq
  import smm_pkg::*;
#(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PORT_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smi_i,
  input  logic              rsm_i,
  input  logic              init_i,
  input  logic              nmi_i,
  input  logic              halted_i,
  input  logic              io_act_i,
  input  logic [PORT_W-1:0] io_port_i,
  input  logic [1:0]        io_size_i,
  input  logic              io_rep_i,
  input  logic              io_str_i,
  input  logic              io_in_i,
  input  logic              hdl_wr_i,
  input  logic              hdl_sel_i,
  input  logic [BYTE_W-1:0] hdl_data_i,
  input  logic [REG_W-1:0]  cr0_i,
  input  logic              cr4_pae_i,
  input  logic              efer_lme_i,
  input  logic              cs_l_i,
  input  logic              cs_d_i,
  input  logic [REG_W-1:0]  dr6_i,
  input  logic [REG_W-1:0]  dr7_i,
  input  logic              rflags_vm_i,
  input  logic [REG_W-1:0]  seg_base_i,
  input  logic              seg_canon_i,
  output logic              in_smm_o,
  output logic              shutdown_o,
  output logic [BYTE_W-1:0] auto_halt_o,
  output logic [BYTE_W-1:0] io_restart_o,
  output logic [31:0]       io_status_o,
  output logic              rsm_shut_o,
  output logic              rsm_halt_o,
  output logic              rsm_iorst_o,
  output logic              rsm_cont_o,
  output logic              conflict_o,
  output logic              ud_o,
  output logic              halt_cyc_o,
  output logic              lma_o,
  output logic              vm_o,
  output logic [REG_W-1:0]  base_o
);
  smm_st_e          st_q;
  logic [31:0]      trap_word;
  logic             img_bad;
  logic [REG_W-1:0] base_fixed;
  logic             lma_new;
  logic             ah_set, io_set;

  smm_io_pack #(.PORT_W(PORT_W)) u_pack (
    .act_i(io_act_i), .port_i(io_port_i), .size_i(io_size_i),
    .rep_i(io_rep_i), .str_i(io_str_i), .in_i(io_in_i), .word_o(trap_word)
  );

  smm_img_check #(.REG_W(REG_W)) u_chk (
    .cr0_i(cr0_i), .pae_i(cr4_pae_i), .lme_i(efer_lme_i), .cs_l_i(cs_l_i),
    .cs_d_i(cs_d_i), .dr6_i(dr6_i), .dr7_i(dr7_i), .bad_o(img_bad)
  );

  smm_base_fix #(.REG_W(REG_W), .VA_W(VA_W)) u_base (
    .base_i(seg_base_i), .canon_i(seg_canon_i), .base_o(base_fixed)
  );

  assign lma_new    = efer_lme_i & cr0_i[CR0_PG] & cr4_pae_i;
  assign ah_set     = |auto_halt_o;
  assign io_set     = |io_restart_o;
  assign in_smm_o   = (st_q == ST_SMM);
  assign shutdown_o = (st_q == ST_SHUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_RUN;
      auto_halt_o  <= '0;
      io_restart_o <= '0;
      io_status_o  <= '0;
      rsm_shut_o   <= 1'b0;
      rsm_halt_o   <= 1'b0;
      rsm_iorst_o  <= 1'b0;
      rsm_cont_o   <= 1'b0;
      conflict_o   <= 1'b0;
      ud_o         <= 1'b0;
      halt_cyc_o   <= 1'b0;
      lma_o        <= 1'b0;
      vm_o         <= 1'b0;
      base_o       <= '0;
    end else begin
      rsm_shut_o  <= 1'b0;
      rsm_halt_o  <= 1'b0;
      rsm_iorst_o <= 1'b0;
      rsm_cont_o  <= 1'b0;
      conflict_o  <= 1'b0;
      ud_o        <= 1'b0;
      halt_cyc_o  <= rsm_halt_o;
      unique case (st_q)
        ST_RUN: begin
          if (smi_i) begin
            st_q         <= ST_SMM;
            auto_halt_o  <= {{(BYTE_W-1){1'b0}}, halted_i};
            io_restart_o <= '0;
            io_status_o  <= trap_word;
          end else if (rsm_i) begin
            ud_o <= 1'b1;
          end
        end
        ST_SMM: begin
          if (rsm_i) begin
            if (img_bad) begin
              st_q       <= ST_SHUT;
              rsm_shut_o <= 1'b1;
            end else begin
              st_q   <= ST_RUN;
              lma_o  <= lma_new;
              vm_o   <= rflags_vm_i & cr0_i[CR0_PE] & ~lma_new;
              base_o <= base_fixed;
              if (io_set) begin
                rsm_iorst_o <= 1'b1;
                conflict_o  <= ah_set;
              end else if (ah_set) begin
                rsm_halt_o <= 1'b1;
              end else begin
                rsm_cont_o <= 1'b1;
              end
            end
          end else if (hdl_wr_i) begin
            if (hdl_sel_i) io_restart_o <= hdl_data_i;
            else           auto_halt_o  <= hdl_data_i;
          end
        end
        ST_SHUT: begin
          if (init_i || nmi_i) st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  // R8
  outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsm_shut_o, rsm_halt_o, rsm_iorst_o, rsm_cont_o}));
  // R8
  conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> rsm_iorst_o && auto_halt_o != '0 && io_restart_o != '0);
  // R1
  entry_ah_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_smm_o) |-> auto_halt_o[BYTE_W-1:1] == '0);
  // R2
  entry_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_smm_o) |-> io_restart_o == '0);
  // R7
  shut_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o && !init_i && !nmi_i |=> shutdown_o);
  // R5
  ud_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_o |-> !in_smm_o && !shutdown_o && !rsm_cont_o && !rsm_halt_o);
  // R3
  status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_status_o[1] |-> io_status_o == 32'h0);
  // R4
  smi_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_smm_o && smi_i && !rsm_i |=> $stable(io_status_o));
endmodule

// File: tb/sim_smm_seq.sv
module sim_smm_seq;
  localparam int VA = 48;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic smi = 0, rsm = 0, init = 0, nmi = 0, halted = 0, io_act = 0;
  logic [15:0] io_port = 0; logic [1:0] io_size = 0;
  logic io_rep = 0, io_str = 0, io_in = 0, hdl_wr = 0, hdl_sel = 0;
  logic [7:0] hdl_data = 0;
  logic [63:0] cr0 = 64'h1, dr6 = 0, dr7 = 0, sbase = 0;
  logic pae = 0, lme = 0, csl = 0, csd = 0, vmf = 0, canon = 0;
  logic in_smm, shut, rs_shut, rs_halt, rs_io, rs_cont, confl, ud, hcyc, lma, vm;
  logic [7:0] ah, iob; logic [31:0] stat; logic [63:0] base;

  smm_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .smi_i(smi), .rsm_i(rsm), .init_i(init), .nmi_i(nmi),
    .halted_i(halted), .io_act_i(io_act), .io_port_i(io_port), .io_size_i(io_size),
    .io_rep_i(io_rep), .io_str_i(io_str), .io_in_i(io_in), .hdl_wr_i(hdl_wr),
    .hdl_sel_i(hdl_sel), .hdl_data_i(hdl_data), .cr0_i(cr0), .cr4_pae_i(pae),
    .efer_lme_i(lme), .cs_l_i(csl), .cs_d_i(csd), .dr6_i(dr6), .dr7_i(dr7),
    .rflags_vm_i(vmf), .seg_base_i(sbase), .seg_canon_i(canon),
    .in_smm_o(in_smm), .shutdown_o(shut), .auto_halt_o(ah), .io_restart_o(iob),
    .io_status_o(stat), .rsm_shut_o(rs_shut), .rsm_halt_o(rs_halt),
    .rsm_iorst_o(rs_io), .rsm_cont_o(rs_cont), .conflict_o(confl), .ud_o(ud),
    .halt_cyc_o(hcyc), .lma_o(lma), .vm_o(vm), .base_o(base)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic a, input logic [15:0] p,
      input logic [1:0] s, input logic r, input logic st, input logic i);
    logic [2:0] z;
    z = (s == 0) ? 3'b001 : (s == 1) ? 3'b010 : (s == 2) ? 3'b100 : 3'b000;
    return a ? {p, 9'b0, z, r, st, 1'b1, i} : 32'h0;
  endfunction

  function automatic logic exp_bad();
    return (!cr0[0] && cr0[31]) || (!cr0[30] && cr0[29]) || (cr0[63:32] != 0) ||
           (dr6[63:32] != 0) || (dr7[63:32] != 0) || (lme && cr0[31] && !pae) ||
           (lme && cr0[31] && pae && csl && csd);
  endfunction

  function automatic logic [63:0] exp_base();
    logic t;
    t = canon & sbase[VA-1];
    return {{(64-VA){t}}, sbase[VA-1:0]};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_smi();
    smi = 1; step(); smi = 0;
  endtask

  task automatic do_wr(input logic sel, input logic [7:0] d);
    hdl_wr = 1; hdl_sel = sel; hdl_data = d; step(); hdl_wr = 0;
  endtask

  task automatic rand_img();
    cr0 = 64'h0;
    cr0[0] = $urandom_range(0, 3) != 0;
    cr0[31] = $urandom_range(0, 1);
    cr0[30] = $urandom_range(0, 1);
    cr0[29] = $urandom_range(0, 3) == 0;
    if ($urandom_range(0, 7) == 0) cr0[32 + $urandom_range(0, 31)] = 1'b1;
    dr6 = 0; dr7 = 0;
    if ($urandom_range(0, 15) == 0) dr6[63] = 1'b1;
    if ($urandom_range(0, 15) == 0) dr7[40] = 1'b1;
    pae = $urandom_range(0, 1); lme = $urandom_range(0, 1);
    csl = $urandom_range(0, 1); csd = $urandom_range(0, 1);
    vmf = $urandom_range(0, 1); canon = $urandom_range(0, 1);
    sbase = {$urandom(), $urandom()};
  endtask

  // Issue a resume from SMM and check the outcome against the requirements.
  task automatic do_rsm(input logic [7:0] eah, input logic [7:0] eio);
    logic bad, elma, ehalt;
    logic [3:0] exp_oc;
    bad = exp_bad();
    elma = lme & cr0[31] & pae;
    rsm = 1; step(); rsm = 0;
    if (bad) exp_oc = 4'b1000;
    else if (eio != 0) exp_oc = 4'b0010;
    else if (eah != 0) exp_oc = 4'b0100;
    else exp_oc = 4'b0001;
    ehalt = exp_oc[2];
    chk("R8 outcome", {rs_shut, rs_halt, rs_io, rs_cont}, exp_oc);
    chk("R8 conflict", confl, !bad && eio != 0 && eah != 0);
    if (bad) begin
      chk("R6 shutdown", shut, 1);
    end else begin
      chk("R10 lma", lma, elma);
      chk("R10 vm", vm, vmf & cr0[0] & ~elma);
      chk("R11 base", base, exp_base());
      chk("R8 back to run", {in_smm, shut}, 2'b00);
    end
    step();
    chk("R9 halt cycle", hcyc, ehalt);
    chk("R8 pulse width", {rs_shut, rs_halt, rs_io, rs_cont}, 4'b0);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    step(); step(); rst_n = 1; step();
    chk("R1 reset state", {in_smm, shut, ah, iob, stat}, '0);

    // R5: resume outside SMM
    rsm = 1; step(); rsm = 0;
    chk("R5 ud pulse", {ud, rs_cont, rs_halt, rs_io, rs_shut, in_smm}, 6'b100000);
    step();
    chk("R5 ud one cycle", ud, 0);

    // R1 R3: halted entry with a 16-bit IN trap
    halted = 1; io_act = 1; io_port = 16'h1f0; io_size = 1; io_rep = 1; io_str = 0; io_in = 1;
    do_smi();
    chk("R1 ah halted", ah, 8'h01);
    chk("R2 io cleared", iob, 8'h00);
    chk("R3 status", stat, exp_word(1, 16'h1f0, 1, 1, 0, 1));
    // R4: second SMI ignored
    do_wr(0, 8'h55);
    halted = 0; io_act = 0;
    do_smi();
    chk("R4 ah kept", ah, 8'h55);
    chk("R4 status kept", stat, exp_word(1, 16'h1f0, 1, 1, 0, 1));
    chk("R4 still smm", in_smm, 1);
    do_wr(1, 8'h03);
    chk("R2 io write", iob, 8'h03);
    cr0 = 64'h8000_0011; pae = 1; lme = 1; csl = 1; csd = 0; vmf = 1; canon = 1;
    sbase = 64'h0000_8000_1234_5678; dr6 = 0; dr7 = 0;
    do_rsm(8'h55, 8'h03);

    // R3: no I/O trap gives zero word; R11 clear variant
    halted = 0; io_act = 0; do_smi();
    chk("R3 word zero", stat, 32'h0);
    chk("R1 ah not halted", ah, 8'h00);
    canon = 0; lme = 0; cr0 = 64'h1; sbase = 64'hffff_ffff_ffff_ffff;
    do_rsm(8'h00, 8'h00);

    // R6 R7: bad image, shutdown ignores RSM/SMI, NMI leaves
    do_smi();
    cr0 = 64'h8000_0000;
    do_rsm(8'h00, 8'h00);
    rsm = 1; smi = 1; step(); rsm = 0; smi = 0;
    chk("R6 shut holds", {shut, in_smm, rs_cont, ud}, 4'b1000);
    nmi = 1; step(); nmi = 0;
    chk("R7 nmi exit", {shut, in_smm}, 2'b00);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      logic a, h, rp, sr, in; logic [15:0] p; logic [1:0] s; logic [7:0] wa, wi;
      h = $urandom_range(0, 1); a = $urandom_range(0, 1); p = $urandom();
      s = $urandom_range(0, 3); rp = $urandom_range(0, 1); sr = $urandom_range(0, 1);
      in = $urandom_range(0, 1);
      halted = h; io_act = a; io_port = p; io_size = s; io_rep = rp; io_str = sr; io_in = in;
      do_smi();
      chk("R1 rand ah", ah, {7'b0, h});
      chk("R2 rand io", iob, 8'h00);
      chk("R3 rand status", stat, exp_word(a, p, s, rp, sr, in));
      wa = {7'b0, h}; wi = 8'h00;
      if ($urandom_range(0, 1)) begin
        wa = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(1, 255)) : 8'h00;
        do_wr(0, wa);
      end
      if ($urandom_range(0, 1)) begin
        wi = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(1, 255)) : 8'h00;
        do_wr(1, wi);
      end
      rand_img();
      do_rsm(wa, wi);
      if (shut) begin
        if (it % 2 == 0) begin init = 1; step(); init = 0; end
        else begin nmi = 1; step(); nmi = 0; end
        chk("R7 rand exit", {shut, in_smm}, 2'b00);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule